// File: doc/BRIEF.md
# Sensor-Driven Highway and Farm Road Signal Controller

This block drives the signal lamps at a crossing where a busy highway meets a minor farm road. The highway shows green by default. A single presence sensor on the farm road approach is the only control input. When it reports a waiting vehicle, the controller steps the highway through yellow and a full stop. It then gives the farm road green for as long as the sensor stays asserted. After that it steps the farm road through yellow and a second full stop, and the highway gets green again.

The controller is a Moore machine with six states held in a 3-bit register. Each of the six lamp outputs is decoded from the current state alone. No timers exist. Every transitional phase (a yellow or an all-red) lasts exactly one clock, and farm green lasts only as long as the sensor level holds it. Reset is synchronous and active low. Any state code outside the six in use falls back to highway green on the next clock.

Top module: `farm_junction_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is highway green with farm red. With the sensor low, the controller stays in that state.
- R2: In the highway-green state, a high sensor at a rising edge moves the controller to highway yellow with farm red on that edge.
- R3: From highway yellow the controller takes one clock to reach the entry all-red state (both roads red). It takes one more clock to reach farm green with highway red. Both steps happen whatever the sensor level is.
- R4: Farm green is held for every clock edge at which the sensor is high.
- R5: In the farm-green state, a low sensor at a rising edge moves the controller to farm yellow with highway red. It then takes one clock to reach the exit all-red state and one more to reach highway green with farm red. These steps happen whatever the sensor level is.
- R6: Whenever one road shows green or yellow, the other road shows red.
- R7: Each road has exactly one of its three lamps lit in every state.
- R8: A sensor pulse one clock wide, seen in highway green, still produces exactly one clock of farm green before the return sequence starts.
- R9: A low `rst_n` in the middle of a sequence returns the lamps to highway green with farm red on the next rising edge, even with the sensor high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| car_sense | input | 1 | High while a vehicle waits on the farm road |
| hwy_grn | output | 1 | Highway green lamp |
| hwy_yel | output | 1 | Highway yellow lamp |
| hwy_red | output | 1 | Highway red lamp |
| frm_grn | output | 1 | Farm road green lamp |
| frm_yel | output | 1 | Farm road yellow lamp |
| frm_red | output | 1 | Farm road red lamp |

## Verification
The sensor is driven in several patterns:
- A long stretch held low shows that the highway keeps its green.
- A steady high level run through a full cycle separates holding farm green from leaving it.
- Toggling the sensor during the yellow and all-red phases shows that those phases ignore it.
- A one-clock pulse separates "green for at least one clock" from a skipped farm green.

A reset asserted partway through the cycle, with the sensor still high, shows that reset takes priority over the sequence.

// File: rtl/junction_pkg.sv
// Shared definitions for the junction signal controller.
// Assumes six phases packed into a 3-bit code; codes 6 and 7 are unused.
package junction_pkg;

    localparam int PHASE_W = 3;
    localparam int NUM_ROADS = 2;

    // Phase order follows the light sequence around the full cycle.
    typedef enum logic [PHASE_W-1:0] {
        HWY_GO       = 3'd0,
        HWY_SLOW     = 3'd1,
        STOP_INTO    = 3'd2,
        FRM_GO       = 3'd3,
        FRM_SLOW     = 3'd4,
        STOP_OUTOF   = 3'd5
    } phase_t;

    // One road's lamp set.
    typedef struct packed {
        logic grn;
        logic yel;
        logic red;
    } lamp_t;

endpackage

// File: rtl/junction_next.sv
// Next-phase logic for the junction controller.
// Only the two green phases look at the sensor; every yellow and all-red
// phase advances unconditionally. Unused codes recover to highway green.
module junction_next
    import junction_pkg::*;
(
    input  phase_t cur_phase,
    input  logic   car_here,
    output phase_t nxt_phase
);

    // Purpose: select the following phase from the current one and the sensor.
    always_comb begin
        unique case (cur_phase)
            HWY_GO:     nxt_phase = car_here ? HWY_SLOW : HWY_GO;
            HWY_SLOW:   nxt_phase = STOP_INTO;
            STOP_INTO:  nxt_phase = FRM_GO;
            FRM_GO:     nxt_phase = car_here ? FRM_GO : FRM_SLOW;
            FRM_SLOW:   nxt_phase = STOP_OUTOF;
            STOP_OUTOF: nxt_phase = HWY_GO;
            default:    nxt_phase = HWY_GO;
        endcase
    end

endmodule

// File: rtl/junction_lamps.sv
// Lamp decode for one road. The road's green and yellow phases are given by
// parameter; the road shows red in every other phase. Purely combinational.
module junction_lamps
    import junction_pkg::*;
#(
    parameter phase_t GO_PHASE   = HWY_GO,
    parameter phase_t SLOW_PHASE = HWY_SLOW
) (
    input  phase_t cur_phase,
    output lamp_t  lamps
);

    // Purpose: light exactly one lamp for this road from the current phase.
    always_comb begin
        lamps = '{grn: 1'b0, yel: 1'b0, red: 1'b0};
        if (cur_phase == GO_PHASE)
            lamps.grn = 1'b1;
        else if (cur_phase == SLOW_PHASE)
            lamps.yel = 1'b1;
        else
            lamps.red = 1'b1;
    end

endmodule

// File: rtl/farm_junction_ctrl.sv
// Top of the highway / farm road signal controller (Moore machine).
// Holds the phase register, instantiates the next-phase logic and one lamp
// decoder per road. Reset is synchronous, active low. The sensor is assumed
// already synchronised to clk.
module farm_junction_ctrl
    import junction_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic car_sense,
    output logic hwy_grn,
    output logic hwy_yel,
    output logic hwy_red,
    output logic frm_grn,
    output logic frm_yel,
    output logic frm_red
);

    phase_t state_q;
    phase_t state_d;
    lamp_t  road_lamps [NUM_ROADS];

    junction_next u_next (
        .cur_phase (state_q),
        .car_here  (car_sense),
        .nxt_phase (state_d)
    );

    // Purpose: phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= HWY_GO;
        else
            state_q <= state_d;
    end

    // Road 0 is the highway, road 1 the farm road.
    for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
        localparam phase_t GO_P   = (r == 0) ? HWY_GO   : FRM_GO;
        localparam phase_t SLOW_P = (r == 0) ? HWY_SLOW : FRM_SLOW;
        junction_lamps #(
            .GO_PHASE   (GO_P),
            .SLOW_PHASE (SLOW_P)
        ) u_lamps (
            .cur_phase (state_q),
            .lamps     (road_lamps[r])
        );
    end

    // Purpose: drive the lamp ports from the per-road decoders.
    always_comb begin
        hwy_grn = road_lamps[0].grn;
        hwy_yel = road_lamps[0].yel;
        hwy_red = road_lamps[0].red;
        frm_grn = road_lamps[1].grn;
        frm_yel = road_lamps[1].yel;
        frm_red = road_lamps[1].red;
    end

endmodule

// File: rtl/junction_checker.sv
// Property checker for farm_junction_ctrl, attached by bind below.
// Observes the ports and the phase register; drives nothing.
module junction_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       car_sense,
    input logic       hwy_grn,
    input logic       hwy_yel,
    input logic       hwy_red,
    input logic       frm_grn,
    input logic       frm_yel,
    input logic       frm_red,
    input logic [2:0] state_q
);

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_grn && !car_sense) |=> hwy_grn && frm_red);

    a_r1_unused_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q > 3'd5) |=> (hwy_grn && frm_red));

    a_r2_leave_highway: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_grn && car_sense) |=> (hwy_yel && frm_red));

    a_r3_into_stop: assert property (@(posedge clk) disable iff (!rst_n)
        hwy_yel |=> (hwy_red && frm_red));

    a_r3_into_farm: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_red && frm_red && $past(hwy_yel)) |=> (frm_grn && hwy_red));

    a_r4_farm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_grn && car_sense) |=> frm_grn);

    a_r5_leave_farm: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_grn && !car_sense) |=> (frm_yel && hwy_red));

    a_r5_outof_stop: assert property (@(posedge clk) disable iff (!rst_n)
        frm_yel |=> (hwy_red && frm_red));

    a_r5_back_home: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_red && frm_red && $past(frm_yel)) |=> (hwy_grn && frm_red));

    a_r6_cross_red: assert property (@(posedge clk) disable iff (!rst_n)
        ((hwy_grn || hwy_yel) |-> frm_red) and ((frm_grn || frm_yel) |-> hwy_red));

    a_r7_one_lamp: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({hwy_grn, hwy_yel, hwy_red}) == 1)
        && ($countones({frm_grn, frm_yel, frm_red}) == 1));

endmodule

bind farm_junction_ctrl junction_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .car_sense (car_sense),
    .hwy_grn   (hwy_grn),
    .hwy_yel   (hwy_yel),
    .hwy_red   (hwy_red),
    .frm_grn   (frm_grn),
    .frm_yel   (frm_yel),
    .frm_red   (frm_red),
    .state_q   (state_q)
);

// File: tb/farm_junction_ctrl_test.sv
// Directed bench: one task per scenario, each checking its own results.
module farm_junction_ctrl_test;

    // Lamp patterns {hg, hy, hr, fg, fy, fr}
    localparam logic [5:0] P_HG = 6'b100_001;
    localparam logic [5:0] P_HY = 6'b010_001;
    localparam logic [5:0] P_AR = 6'b001_001;
    localparam logic [5:0] P_FG = 6'b001_100;
    localparam logic [5:0] P_FY = 6'b001_010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic car_sense = 1'b0;
    logic hwy_grn, hwy_yel, hwy_red, frm_grn, frm_yel, frm_red;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    farm_junction_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .car_sense (car_sense),
        .hwy_grn   (hwy_grn),
        .hwy_yel   (hwy_yel),
        .hwy_red   (hwy_red),
        .frm_grn   (frm_grn),
        .frm_yel   (frm_yel),
        .frm_red   (frm_red)
    );

    function automatic logic [5:0] lamps_now();
        return {hwy_grn, hwy_yel, hwy_red, frm_grn, frm_yel, frm_red};
    endfunction

    task automatic check(input logic [5:0] exp, input string tag);
        logic [5:0] act;
        act = lamps_now();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: lamps %b, expected %b", tag, act, exp);
        end
        // R6 and R7 hold in every observed state
        checks++;
        if (($countones(act[5:3]) != 1) || ($countones(act[2:0]) != 1)
            || ((act[5] || act[4]) && !act[0]) || ((act[2] || act[1]) && !act[3])) begin
            errors++;
            $display("FAIL R6/R7: lamps %b, expected one lamp per road with cross red", act);
        end
    endtask

    // Drive the sensor at the falling edge, then sample just after the rising edge.
    task automatic step(input logic car, input logic [5:0] exp, input string tag);
        @(negedge clk);
        car_sense = car;
        @(posedge clk);
        #1;
        check(exp, tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        car_sense = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(P_HG, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        for (int i = 0; i < 6; i++) step(1'b0, P_HG, "R1 idle hold");
    endtask

    task automatic t_full_cycle();
        step(1'b1, P_HY, "R2 highway yellow");
        step(1'b1, P_AR, "R3 entry all-red");
        step(1'b1, P_FG, "R3 farm green");
        for (int i = 0; i < 4; i++) step(1'b1, P_FG, "R4 farm green held");
        step(1'b0, P_FY, "R5 farm yellow");
        step(1'b0, P_AR, "R5 exit all-red");
        step(1'b0, P_HG, "R5 highway green");
        step(1'b0, P_HG, "R1 hold after return");
    endtask

    task automatic t_ignore_sensor();
        step(1'b1, P_HY, "R2 highway yellow");
        step(1'b0, P_AR, "R3 sensor ignored in yellow");
        step(1'b0, P_FG, "R3 sensor ignored in all-red");
        step(1'b0, P_FY, "R5 farm yellow");
        step(1'b1, P_AR, "R5 sensor ignored in yellow");
        step(1'b1, P_HG, "R5 sensor ignored in all-red");
        step(1'b1, P_HY, "R2 immediate re-request");
        step(1'b1, P_AR, "R3 entry all-red");
        step(1'b1, P_FG, "R3 farm green");
        step(1'b0, P_FY, "R5 farm yellow");
        step(1'b0, P_AR, "R5 exit all-red");
        step(1'b0, P_HG, "R5 highway green");
    endtask

    task automatic t_short_pulse();
        step(1'b1, P_HY, "R8 pulse starts sequence");
        step(1'b0, P_AR, "R8 entry all-red");
        step(1'b0, P_FG, "R8 one farm green clock");
        step(1'b0, P_FY, "R8 farm yellow follows");
        step(1'b0, P_AR, "R8 exit all-red");
        step(1'b0, P_HG, "R8 back to highway");
    endtask

    task automatic t_reset_mid();
        step(1'b1, P_HY, "R2 highway yellow");
        step(1'b1, P_AR, "R3 entry all-red");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(P_HG, "R9 reset mid-sequence");
        @(posedge clk);
        #1;
        check(P_HG, "R9 reset held with sensor high");
        @(negedge clk);
        rst_n = 1'b1;
        car_sense = 1'b0;
        step(1'b0, P_HG, "R1 idle after reset");
    endtask

    initial begin
        t_reset();
        t_idle();
        t_full_cycle();
        t_ignore_sensor();
        t_short_pulse();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected finish within 5000 clocks");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule